// File: doc/BRIEF.md
# Byte-Reversing Indexed Word Load Unit

This execution unit serves a 64-bit processor that keeps big-endian order in its registers. It takes one 32-bit instruction word at a time and recognises a single indexed load. That load fetches a 4-byte word stored in little-endian order and puts it into a register.

The register fields of the instruction select two operands through a combinational register-file read port. The effective address is their sum, where a base field of zero means the constant zero. The unit places that address on a valid/ready read port, and only one read is ever in flight. When the read data comes back, the unit reverses the order of its four bytes. It then zero-extends the result and presents it for one cycle on a write-back port, together with the destination index and the address of the next instruction. Any other instruction word is refused with a one-cycle illegal flag, and no memory traffic follows.

The reset `rst_n` is asynchronous and active low. Its deassertion is expected to arrive synchronised to `clk`.

Top module: `brev_load_unit`

## Requirements
- R1: An accepted word is legal only when bits 31:26 equal 31 and bits 10:1 equal 534. For any other accepted word, `illegal_instr` is high for exactly the one cycle after acceptance, no read request follows, and `instr_ready` stays high.
- R2: The destination index is taken from bits 25:21, source A from bits 20:16 and source B from bits 15:11. These indices drive `rf_rd_a_idx` and `rf_rd_b_idx`, and the destination index appears on `wb_idx`. Bit 0 (the record flag) has no effect on decoding or on results.
- R3: The effective address is (A==0 ? 0 : reg[A]) + reg[B]. The sum is taken modulo 2^64, and its low 32 bits appear on `mem_req_addr`.
- R4: `mem_req_valid` rises in the cycle after a legal word is accepted. It stays high with a stable `mem_req_addr` until `mem_req_ready` is sampled high, and it drops in the following cycle.
- R5: At most one read is outstanding. `instr_ready` is high only when the unit is idle. `instr_valid` is ignored while the unit is busy, and `mem_rsp_valid` is ignored unless a read is awaiting its data.
- R6: `mem_rsp_data[31:24]` holds the byte at the effective address and `[7:0]` holds the byte at address+3. The result is `{rsp[7:0], rsp[15:8], rsp[23:16], rsp[31:24]}`, so the byte at the effective address becomes the least significant byte.
- R7: `wb_data[63:32]` is zero on every write-back. No sign extension is performed.
- R8: `wb_valid` is high for exactly one cycle, in the cycle after the response is taken. In that cycle `wb_next_pc` equals the accepted `instr_pc` + 4, and exactly one write-back is made per legal instruction.
- R9: Addresses that are not word aligned are issued as ordinary 4-byte reads. `mem_req_misaligned` is high alongside `mem_req_valid` exactly when `mem_req_addr[1:0]` is nonzero.
- R10: During reset, and also after a reset in the middle of an instruction, the unit is idle: `instr_ready` is high and `mem_req_valid`, `wb_valid`, `illegal_instr` and `mem_req_misaligned` are all low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| instr_pc | input | 64 | Address of the offered instruction |
| instr_ready | output | 1 | Unit idle; an offered word is taken at this edge |
| rf_rd_a_idx | output | 5 | Register-file read index, source A |
| rf_rd_a_data | input | 64 | Register-file data for source A (same cycle) |
| rf_rd_b_idx | output | 5 | Register-file read index, source B |
| rf_rd_b_data | input | 64 | Register-file data for source B (same cycle) |
| mem_req_valid | output | 1 | Read request |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_misaligned | output | 1 | Request address not word aligned |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, lowest address in the top byte |
| wb_valid | output | 1 | One-cycle write-back strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Byte-reversed, zero-extended word |
| wb_next_pc | output | 64 | Next instruction address |
| illegal_instr | output | 1 | One-cycle flag for an unrecognised word |

## Verification
The assertions watch the handshake rules on every cycle:
- a request held stable until it is taken, then withdrawn;
- never a request while ready for a new instruction;
- a single-cycle write-back that follows a response and has a zero upper half;
- a misalignment flag only with a request;
- an illegal flag that never coincides with memory traffic.

Only the bench scenarios can show that the values are right:
- the decoded opcode pair;
- the zero-base rule and the wrapped 64-bit sum;
- the byte order of the result;
- the next-PC value;
- that busy-time instructions and stray responses are ignored;
- recovery from a reset in the middle of an instruction.

// File: rtl/brl_pkg.sv
package brl_pkg;

  // Register index width of the architecture (32 general registers).
  localparam int BRL_IDX_W = 5;

  // Opcode pair of the byte-reversed indexed word load.
  localparam logic [5:0] BRL_PRIMARY  = 6'd31;
  localparam logic [9:0] BRL_EXTENDED = 10'd534;

  typedef enum logic [1:0] {
    BRL_IDLE   = 2'd0,
    BRL_ISSUE  = 2'd1,
    BRL_WAIT   = 2'd2,
    BRL_RETIRE = 2'd3
  } brl_state_e;

  typedef struct packed {
    logic                 legal;
    logic                 base_zero;
    logic [BRL_IDX_W-1:0] dst;
    logic [BRL_IDX_W-1:0] src_a;
    logic [BRL_IDX_W-1:0] src_b;
  } brl_fields_t;

endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output brl_fields_t        fields
);
  localparam int PO_W   = 6;
  localparam int XO_W   = 10;
  localparam int PO_LSB = INSTR_W - PO_W;
  localparam int RT_LSB = PO_LSB - BRL_IDX_W;
  localparam int RA_LSB = RT_LSB - BRL_IDX_W;
  localparam int RB_LSB = RA_LSB - BRL_IDX_W;
  localparam int XO_LSB = 1;

  logic [PO_W-1:0] primary;
  logic [XO_W-1:0] extended;
  logic            unused_rc;

  assign primary   = instr[PO_LSB +: PO_W];
  assign extended  = instr[XO_LSB +: XO_W];
  assign unused_rc = instr[0];

  always_comb begin
    fields.legal     = (primary == BRL_PRIMARY) && (extended == BRL_EXTENDED);
    fields.dst       = instr[RT_LSB +: BRL_IDX_W];
    fields.src_a     = instr[RA_LSB +: BRL_IDX_W];
    fields.src_b     = instr[RB_LSB +: BRL_IDX_W];
    fields.base_zero = (instr[RA_LSB +: BRL_IDX_W] == '0);
  end
endmodule

// File: rtl/brl_agen.sv
module brl_agen #(
  parameter int XLEN       = 64,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic            base_is_zero,
  output logic [AW-1:0]   addr,
  output logic            misaligned
);
  localparam int OFS_W = $clog2(WORD_BYTES);

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] sum;
  logic            unused_hi;

  assign base_eff   = base_is_zero ? '0 : base_val;
  assign sum        = base_eff + index_val;
  assign addr       = sum[AW-1:0];
  assign misaligned = |sum[OFS_W-1:0];
  assign unused_hi  = ^sum[XLEN-1:AW];
endmodule

// File: rtl/brl_byteswap.sv
module brl_byteswap #(
  parameter int WORD_BYTES = 4,
  parameter int XLEN       = 64
) (
  input  logic [8*WORD_BYTES-1:0] word_in,
  output logic [XLEN-1:0]         value_out
);
  localparam int DW = 8 * WORD_BYTES;

  logic [DW-1:0] swapped;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign swapped[8*g +: 8] = word_in[8*(WORD_BYTES-1-g) +: 8];
  end

  assign value_out = {{(XLEN-DW){1'b0}}, swapped};
endmodule

// File: rtl/brev_load_unit.sv
module brev_load_unit
  import brl_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int AW         = 32,
  parameter int INSTR_W    = 32,
  parameter int WORD_BYTES = 4,
  parameter int PC_STEP    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr_word,
  input  logic [XLEN-1:0]      instr_pc,
  output logic                 instr_ready,
  output logic [BRL_IDX_W-1:0] rf_rd_a_idx,
  input  logic [XLEN-1:0]      rf_rd_a_data,
  output logic [BRL_IDX_W-1:0] rf_rd_b_idx,
  input  logic [XLEN-1:0]      rf_rd_b_data,
  output logic                 mem_req_valid,
  output logic [AW-1:0]        mem_req_addr,
  output logic                 mem_req_misaligned,
  input  logic                 mem_req_ready,
  input  logic                 mem_rsp_valid,
  input  logic [8*WORD_BYTES-1:0] mem_rsp_data,
  output logic                 wb_valid,
  output logic [BRL_IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic [XLEN-1:0]      wb_next_pc,
  output logic                 illegal_instr
);
  brl_state_e  state_q, state_d;
  brl_fields_t dec;
  logic [AW-1:0]   ea;
  logic            ea_misaligned;
  logic [XLEN-1:0] swapped_val;

  logic                 accept;
  logic                 capture_en;
  logic                 rsp_take;
  logic                 illegal_d, illegal_q;
  logic [AW-1:0]        addr_q;
  logic                 misal_q;
  logic [BRL_IDX_W-1:0] dst_q;
  logic [XLEN-1:0]      npc_q;
  logic [XLEN-1:0]      data_q;

  brl_decode #(.INSTR_W(INSTR_W)) i_decode (
    .instr  (instr_word),
    .fields (dec)
  );

  assign rf_rd_a_idx = dec.src_a;
  assign rf_rd_b_idx = dec.src_b;

  brl_agen #(.XLEN(XLEN), .AW(AW), .WORD_BYTES(WORD_BYTES)) i_agen (
    .base_val     (rf_rd_a_data),
    .index_val    (rf_rd_b_data),
    .base_is_zero (dec.base_zero),
    .addr         (ea),
    .misaligned   (ea_misaligned)
  );

  brl_byteswap #(.WORD_BYTES(WORD_BYTES), .XLEN(XLEN)) i_swap (
    .word_in   (mem_rsp_data),
    .value_out (swapped_val)
  );

  // Handshake qualifiers.
  assign accept     = instr_valid && (state_q == BRL_IDLE);
  assign capture_en = accept && dec.legal;
  assign rsp_take   = (state_q == BRL_WAIT) && mem_rsp_valid;
  assign illegal_d  = accept && !dec.legal;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BRL_IDLE:   if (capture_en)    state_d = BRL_ISSUE;
      BRL_ISSUE:  if (mem_req_ready) state_d = BRL_WAIT;
      BRL_WAIT:   if (mem_rsp_valid) state_d = BRL_RETIRE;
      BRL_RETIRE:                    state_d = BRL_IDLE;
      default:                       state_d = BRL_IDLE;
    endcase
  end

  // Control registers with reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= BRL_IDLE;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      illegal_q <= illegal_d;
    end
  end

  // Datapath registers, loaded under explicit enables.
  always_ff @(posedge clk) begin
    if (capture_en) begin
      addr_q  <= ea;
      misal_q <= ea_misaligned;
      dst_q   <= dec.dst;
      npc_q   <= instr_pc + XLEN'(PC_STEP);
    end
    if (rsp_take) begin
      data_q <= swapped_val;
    end
  end

  assign instr_ready        = (state_q == BRL_IDLE);
  assign mem_req_valid      = (state_q == BRL_ISSUE);
  assign mem_req_addr       = addr_q;
  assign mem_req_misaligned = (state_q == BRL_ISSUE) && misal_q;
  assign wb_valid           = (state_q == BRL_RETIRE);
  assign wb_idx             = dst_q;
  assign wb_data            = data_q;
  assign wb_next_pc         = npc_q;
  assign illegal_instr      = illegal_q;
endmodule

// File: rtl/brev_load_unit_chk.sv
module brev_load_unit_chk #(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_ready,
  input logic            mem_req_valid,
  input logic [AW-1:0]   mem_req_addr,
  input logic            mem_req_misaligned,
  input logic            mem_req_ready,
  input logic            mem_rsp_valid,
  input logic            wb_valid,
  input logic [XLEN-1:0] wb_data,
  input logic            illegal_instr
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_ready && mem_req_valid));

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[XLEN-1:32] == '0));

  assert_wb_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  assert_wb_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(mem_rsp_valid));

  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_instr |-> (!mem_req_valid && instr_ready && !wb_valid));

  assert_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_misaligned |-> mem_req_valid);
endmodule

bind brev_load_unit brev_load_unit_chk #(.XLEN(XLEN), .AW(AW)) i_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .instr_ready        (instr_ready),
  .mem_req_valid      (mem_req_valid),
  .mem_req_addr       (mem_req_addr),
  .mem_req_misaligned (mem_req_misaligned),
  .mem_req_ready      (mem_req_ready),
  .mem_rsp_valid      (mem_rsp_valid),
  .wb_valid           (wb_valid),
  .wb_data            (wb_data),
  .illegal_instr      (illegal_instr)
);

// File: tb/test_brev_load_unit.sv
`timescale 1ns/1ps
module test_brev_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [63:0] instr_pc = '0;
  logic        instr_ready;
  logic [4:0]  rf_rd_a_idx, rf_rd_b_idx;
  logic [63:0] rf_rd_a_data, rf_rd_b_data;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_misaligned;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic [63:0] wb_next_pc;
  logic        illegal_instr;

  always #5 clk = ~clk;

  brev_load_unit i_brev_load_unit (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_word(instr_word), .instr_pc(instr_pc),
    .instr_ready(instr_ready),
    .rf_rd_a_idx(rf_rd_a_idx), .rf_rd_a_data(rf_rd_a_data),
    .rf_rd_b_idx(rf_rd_b_idx), .rf_rd_b_data(rf_rd_b_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_misaligned(mem_req_misaligned), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .wb_next_pc(wb_next_pc), .illegal_instr(illegal_instr)
  );

  // Register file model.
  logic [63:0] rf [32];
  assign rf_rd_a_data = rf[rf_rd_a_idx];
  assign rf_rd_b_data = rf[rf_rd_b_idx];

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Memory contents are a function of the byte address.
  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [7:0] t;
    t = 8'(a[7:0] * 8'd29);
    return 8'((t ^ a[15:8]) + a[31:24] + 8'h3C);
  endfunction

  function automatic logic [31:0] mword_be(input logic [31:0] a);
    return {mbyte(a), mbyte(a + 32'd1), mbyte(a + 32'd2), mbyte(a + 32'd3)};
  endfunction

  function automatic logic [31:0] mk(input int op, input int rt, input int ra, input int rb, input int xo, input int rc);
    return (32'(op) << 26) | (32'(rt) << 21) | (32'(ra) << 16) | (32'(rb) << 11) | (32'(xo) << 1) | 32'(rc);
  endfunction

  // Reference model, advanced on every rising edge.
  int          m_st = 0;          // 0 idle, 1 request, 2 waiting, 3 write-back
  bit          m_ill = 0;
  logic [31:0] m_addr = '0;
  logic [4:0]  m_dst = '0;
  logic [63:0] m_npc = '0;
  logic [63:0] m_data = '0;
  int          m_wb_expected = 0;
  int          m_wb_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st  = 0;
      m_ill = 0;
    end else begin
      m_ill = 0;
      case (m_st)
        0: if (instr_valid) begin
          int unsigned w, ra, rb;
          logic [63:0] base;
          w  = instr_word;
          ra = (w >> 16) % 32;
          rb = (w >> 11) % 32;
          if ((w >> 26) == 31 && ((w >> 1) % 1024) == 534) begin
            base   = (ra == 0) ? 64'd0 : rf[ra];
            m_addr = 32'(base + rf[rb]);
            m_dst  = 5'((w >> 21) % 32);
            m_npc  = instr_pc + 64'd4;
            m_st   = 1;
            m_wb_expected++;
          end else begin
            m_ill = 1;
          end
        end
        1: if (mem_req_ready) m_st = 2;
        2: if (mem_rsp_valid) begin
          m_data = {32'd0, mbyte(m_addr + 32'd3), mbyte(m_addr + 32'd2),
                    mbyte(m_addr + 32'd1), mbyte(m_addr)};
          m_st = 3;
        end
        default: m_st = 0;
      endcase
    end
  end

  // Compare on every falling edge, plus watchdog.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rst_n) begin
      chk(instr_ready == (m_st == 0), "R5 instr_ready", 64'(instr_ready), 64'(m_st == 0));
      chk(mem_req_valid == (m_st == 1), "R4 mem_req_valid", 64'(mem_req_valid), 64'(m_st == 1));
      chk(illegal_instr == m_ill, "R1 illegal_instr", 64'(illegal_instr), 64'(m_ill));
      chk(wb_valid == (m_st == 3), "R8 wb_valid", 64'(wb_valid), 64'(m_st == 3));
      if (m_st == 1) begin
        chk(mem_req_addr == m_addr, "R3 mem_req_addr", 64'(mem_req_addr), 64'(m_addr));
        chk(mem_req_misaligned == (m_addr[1:0] != 2'b00), "R9 misaligned flag",
            64'(mem_req_misaligned), 64'(m_addr[1:0] != 2'b00));
      end else begin
        chk(!mem_req_misaligned, "R9 misaligned without request", 64'(mem_req_misaligned), 64'd0);
      end
      if (m_st == 3) begin
        m_wb_seen++;
        chk(wb_data[31:0] == m_data[31:0], "R6 reversed word", wb_data, m_data);
        chk(wb_data[63:32] == 32'd0, "R7 upper half zero", wb_data, m_data);
        chk(wb_idx == m_dst, "R2 wb_idx", 64'(wb_idx), 64'(m_dst));
        chk(wb_next_pc == m_npc, "R8 wb_next_pc", wb_next_pc, m_npc);
      end
    end
  end

  // Memory responder, driven on falling edges.
  int          rdy_wait = 0;
  int          rsp_lat = 0;
  int          rdy_cnt = 0;
  int          lat_cnt = 0;
  bit          pend = 0;
  bit          stray_req = 0;
  logic [31:0] pend_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      pend = 0;
      rdy_cnt = 0;
      lat_cnt = 0;
    end else begin
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        pend = 0;
      end else if (pend) begin
        if (lat_cnt >= rsp_lat) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mword_be(pend_addr);
        end else lat_cnt++;
      end
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        pend = 1;
        lat_cnt = 0;
      end else if (mem_req_valid && !pend) begin
        if (rdy_cnt >= rdy_wait) begin
          mem_req_ready = 1'b1;
          pend_addr = mem_req_addr;
          rdy_cnt = 0;
        end else rdy_cnt++;
      end
      if (stray_req && !pend && !mem_rsp_valid && !mem_req_valid && !mem_req_ready) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hDEAD_BEEF;
        stray_req = 0;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!instr_ready || pend || mem_rsp_valid) @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] pc);
    wait_idle();
    instr_valid = 1'b1;
    instr_word  = w;
    instr_pc    = pc;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  localparam int OPL = 31;
  localparam int XOL = 534;

  initial begin
    for (int i = 0; i < 32; i++)
      rf[i] = {32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000, 32'(i) * 32'h0004_0103};
    rf[0] = 64'h0000_0000_FFFF_0000;
    rf[3] = 64'h0000_0000_0000_1000;
    rf[4] = 64'h0000_0000_0000_0020;
    rf[5] = 64'hFFFF_FFFF_FFFF_FFF0;
    rf[6] = 64'h0000_0001_0000_0013;
    rf[8] = 64'h0000_0000_0000_4000;
    rf[9] = 64'h0000_0000_0000_0001;

    // R10: reset state.
    repeat (3) @(negedge clk);
    chk(instr_ready == 1'b1, "R10 instr_ready in reset", 64'(instr_ready), 64'd1);
    chk(!mem_req_valid && !wb_valid && !illegal_instr && !mem_req_misaligned,
        "R10 strobes low in reset", 64'({mem_req_valid, wb_valid, illegal_instr, mem_req_misaligned}), 64'd0);
    rst_n = 1'b1;

    // R3 R6: basic aligned load.
    issue(mk(OPL, 7, 3, 4, XOL, 0), 64'h100);
    // R3: base field zero uses constant zero, not rf[0].
    issue(mk(OPL, 9, 0, 4, XOL, 0), 64'h104);
    // R3: 64-bit wrap and truncation.
    issue(mk(OPL, 10, 5, 6, XOL, 0), 64'h108);
    // R9: misaligned offsets 1..3.
    for (int k = 1; k < 4; k++) begin
      rf[9] = 64'(k);
      issue(mk(OPL, 11, 8, 9, XOL, 0), 64'h10C);
    end
    // R2: record flag set still decodes.
    issue(mk(OPL, 31, 3, 4, XOL, 1), 64'hFFFF_FFFF_FFFF_FFFC);
    // R1: illegal words.
    issue(mk(30, 7, 3, 4, XOL, 0), 64'h200);
    issue(mk(OPL, 7, 3, 4, 533, 0), 64'h204);
    issue(mk(OPL, 7, 3, 4, 23, 0), 64'h208);
    issue(mk(OPL, 7, 3, 4, 535, 0), 64'h20C);
    // R4: stalls on ready and latency on response.
    rdy_wait = 3; rsp_lat = 5;
    issue(mk(OPL, 12, 3, 9, XOL, 0), 64'h300);
    // R5: instr_valid held high while busy is ignored.
    rdy_wait = 4;
    wait_idle();
    instr_valid = 1'b1; instr_word = mk(OPL, 13, 3, 4, XOL, 0); instr_pc = 64'h400;
    @(negedge clk);
    instr_word = mk(30, 14, 5, 6, 1, 0); instr_pc = 64'h900;
    repeat (3) @(negedge clk);
    instr_valid = 1'b0;
    rdy_wait = 0; rsp_lat = 0;
    // R5: stray response while idle is ignored.
    wait_idle();
    stray_req = 1;
    repeat (4) @(negedge clk);
    issue(mk(OPL, 15, 5, 6, XOL, 0), 64'h500);
    // R10: reset during a pending read.
    rsp_lat = 6;
    issue(mk(OPL, 16, 3, 4, XOL, 0), 64'h600);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    m_wb_expected--;
    @(negedge clk);
    chk(instr_ready && !mem_req_valid && !wb_valid && !illegal_instr,
        "R10 idle after mid-flight reset", 64'({instr_ready, mem_req_valid, wb_valid, illegal_instr}), 64'h8);
    @(negedge clk);
    rst_n = 1'b1;
    rsp_lat = 0;
    // R8: back-to-back plus a mixed sweep.
    for (int n = 0; n < 40; n++) begin
      int unsigned r;
      r = $urandom;
      rdy_wait = int'(r % 3);
      rsp_lat  = int'((r >> 2) % 4);
      if ((r >> 5) % 5 == 0)
        issue(mk(int'((r >> 8) % 64), int'((r >> 14) % 32), int'((r >> 19) % 32), int'((r >> 24) % 32), int'((r >> 3) % 1024), 0), 64'(r));
      else
        issue(mk(OPL, int'((r >> 14) % 32), int'((r >> 19) % 32), int'((r >> 24) % 32), XOL, int'((r >> 29) % 2)), 64'(r));
    end
    wait_idle();
    repeat (3) @(negedge clk);
    chk(m_wb_seen == m_wb_expected, "R8 one write-back per legal load",
        64'(m_wb_seen), 64'(m_wb_expected));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule